// File: doc/BRIEF.md
# Path Trace Identifier Mismatch Monitor

This block watches the path trace byte that arrives once per frame on each of three tributary channels. It checks the received bytes, one at a time, against an expected message held in a small per-channel store, and it keeps a trace mismatch state bit for each channel. Each channel can use one of two message formats. The long format has 64 bytes and its start is found from the terminator byte 0x0A: the byte that follows a 0x0A is message byte 0. The short format has 16 bytes, and its start is the byte whose bit 7 is set.

Each channel runs its own state machine with three states. In `S_OFF` the mode code is undefined and the channel does nothing. In `S_HUNT` the channel looks for the start of a message. In `S_CMP` it walks through an aligned message window. The transitions are named as follows. *disable*: any state goes to `S_OFF` when the mode code is undefined. *arm*: `S_OFF` goes to `S_HUNT`, and any state goes to `S_HUNT`, when a valid mode code is new. *lock*: `S_HUNT` goes to `S_CMP` when a start marker arrives. *wrap*: `S_CMP` goes back to `S_CMP` at the end of a long window whose last byte was 0x0A. *lose*: `S_CMP` goes to `S_HUNT` at the end of every other window. *step*: `S_CMP` stays in `S_CMP` in the middle of a window.

The verdict is taken at the end of each window. Whenever the mismatch state changes, the channel's delta bit is set. The delta bit raises the interrupt only when its mask bit is 1.

Top module: `trace_id_monitor`

## Requirements
- R1: Each channel has a 3-bit mode field in `mode_sel` (channel i uses bits 3i+2..3i). Code 3'b100 selects the 64-byte format and 3'b101 selects the 16-byte format. Any other code puts the channel in `S_OFF`: its mismatch bit is 0 one clock after the code is applied, and received bytes do not change it.
- R2: In 64-byte mode, when the channel is in `S_HUNT` and receives 0x0A, the next received byte is compared with expected location 0. A window then covers 64 bytes (locations 0..63). The channel stays aligned only if the 64th byte of the window is 0x0A; otherwise it returns to `S_HUNT`.
- R3: In 16-byte mode, when the channel is in `S_HUNT`, a received byte with bit 7 = 1 is compared with location 0 and starts a 16-byte window (locations 0..15). At the end of the window the channel returns to `S_HUNT`.
- R4: While a channel is in `S_HUNT`, and in any cycle without a received byte, its mismatch bit keeps its previous value.
- R5: The mismatch bit is updated only on the clock edge that takes in the last byte of a window. It becomes 1 if any byte of the window differed from its expected location.
- R6: A window in which every byte matches sets the mismatch bit to 0.
- R7: Any change of a channel's mismatch bit sets its bit in `tim_delta` on the same edge. A 1 in `delta_clr` clears that bit. A new change wins over a clear in the same cycle, and without a clear the bit stays set.
- R8: `irq` is 1 exactly when some channel has both its delta bit and its `irq_mask` bit at 1.
- R9: Channels are independent. A byte with `rx_chan = i` reaches only channel i. An expected-store write with `exp_chan = i` writes `exp_data` to location `exp_addr` of channel i only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, applied synchronously |
| mode_sel | input | 9 | Per-channel 3-bit mode codes |
| rx_vld | input | 1 | Strobe: a received trace byte is present this cycle |
| rx_chan | input | 2 | Channel of the received byte |
| rx_byte | input | 8 | Received trace byte |
| exp_we | input | 1 | Write strobe for the expected-message store |
| exp_chan | input | 2 | Channel to write |
| exp_addr | input | 6 | Location within the message |
| exp_data | input | 8 | Expected byte |
| irq_mask | input | 3 | Per-channel interrupt enable (1 = enabled) |
| delta_clr | input | 3 | Per-channel write-one-to-clear pulse for the delta bits |
| tim_state | output | 3 | Per-channel trace mismatch state |
| tim_delta | output | 3 | Per-channel change flags |
| irq | output | 1 | Masked interrupt |

## Verification
If the byte index drifts by one position, every later window reports a mismatch. This shows on `tim_state` and `tim_delta` at the edge of the first window's last byte, which is at most 64 frames away. If the aligner fails to lock, or locks on the wrong marker, the mismatch bit stays frozen even when a fully good message follows a bad one. If a window is evaluated too early, the bit changes before the last byte, which the bench checks one byte before the end of the window. A lost delta update shows as a missing `irq` in the same cycle as the state change.

// File: rtl/trace_mon_pkg.sv
package trace_mon_pkg;
    localparam int BYTE_W     = 8;
    localparam int MODE_W     = 3;
    localparam logic [MODE_W-1:0] MODE_LONG  = 3'b100;
    localparam logic [MODE_W-1:0] MODE_SHORT = 3'b101;
    localparam logic [BYTE_W-1:0] TERM_BYTE  = 8'h0A;

    typedef enum logic [1:0] {
        S_OFF  = 2'd0,
        S_HUNT = 2'd1,
        S_CMP  = 2'd2
    } trace_state_e;
endpackage

// File: rtl/trace_exp_store.sv
module trace_exp_store #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/trace_chan_fsm.sv
module trace_chan_fsm
    import trace_mon_pkg::*;
#(
    parameter int MSG_LONG  = 64,
    parameter int MSG_SHORT = 16,
    localparam int AW       = $clog2(MSG_LONG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [AW-1:0]     rd_addr,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic              delta_clr,
    output logic              tim_o,
    output logic              delta_o
);
    localparam logic [AW-1:0] LAST_LONG  = AW'(MSG_LONG - 1);
    localparam logic [AW-1:0] LAST_SHORT = AW'(MSG_SHORT - 1);

    trace_state_e      st_q, st_n;
    logic [AW-1:0]     idx_q, idx_n;
    logic              err_q, err_n;
    logic              tim_q, tim_n;
    logic              delta_q, delta_n;
    logic [MODE_W-1:0] mode_q;

    logic          mode_ok, is_long, diff, err_now;
    logic [AW-1:0] last_idx;

    assign mode_ok  = (mode == MODE_LONG) || (mode == MODE_SHORT);
    assign is_long  = (mode == MODE_LONG);
    assign last_idx = is_long ? LAST_LONG : LAST_SHORT;
    assign rd_addr  = idx_q;
    assign diff     = (byte_in != rd_data);
    assign err_now  = err_q | diff;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= S_OFF;
            idx_q   <= '0;
            err_q   <= 1'b0;
            tim_q   <= 1'b0;
            delta_q <= 1'b0;
            mode_q  <= '0;
        end else begin
            st_q    <= st_n;
            idx_q   <= idx_n;
            err_q   <= err_n;
            tim_q   <= tim_n;
            delta_q <= delta_n;
            mode_q  <= mode;
        end
    end

    // next state and verdict
    always_comb begin
        st_n  = st_q;
        idx_n = idx_q;
        err_n = err_q;
        tim_n = tim_q;
        if (!mode_ok) begin
            st_n  = S_OFF;      // disable
            idx_n = '0;
            err_n = 1'b0;
            tim_n = 1'b0;
        end else if ((mode != mode_q) || (st_q == S_OFF)) begin
            st_n  = S_HUNT;     // arm
            idx_n = '0;
            err_n = 1'b0;
        end else if (byte_vld) begin
            unique case (st_q)
                S_HUNT: begin
                    if (is_long && (byte_in == TERM_BYTE)) begin
                        st_n  = S_CMP;  // lock, byte 0 is next
                        idx_n = '0;
                        err_n = 1'b0;
                    end else if (!is_long && byte_in[BYTE_W-1]) begin
                        st_n  = S_CMP;  // lock, this is byte 0
                        idx_n = AW'(1);
                        err_n = diff;
                    end
                end
                S_CMP: begin
                    if (idx_q == last_idx) begin
                        tim_n = err_now;
                        idx_n = '0;
                        err_n = 1'b0;
                        if (is_long && (byte_in == TERM_BYTE)) begin
                            st_n = S_CMP;   // wrap
                        end else begin
                            st_n = S_HUNT;  // lose
                        end
                    end else begin
                        idx_n = idx_q + AW'(1);  // step
                        err_n = err_now;
                    end
                end
                default: begin
                    st_n = S_HUNT;
                end
            endcase
        end
    end

    // delta bookkeeping: a change wins over a clear
    always_comb begin
        delta_n = (delta_q & ~delta_clr) | (tim_n != tim_q);
    end

    // outputs
    always_comb begin
        tim_o   = tim_q;
        delta_o = delta_q;
    end

    // R1
    off_forces_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_ok |=> (tim_q == 1'b0));
    // R4
    hold_without_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ok && !byte_vld) |=> $stable(tim_q));
    // R3
    short_index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == S_CMP) && (mode_q == MODE_SHORT)) |-> (idx_q < AW'(MSG_SHORT)));
    // R7
    change_sets_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tim_q != $past(tim_q)) |-> delta_q);
    // R7
    delta_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (delta_q && !delta_clr) |=> delta_q);
endmodule

// File: rtl/trace_id_monitor.sv
module trace_id_monitor
    import trace_mon_pkg::*;
#(
    parameter int NUM_CH    = 3,
    parameter int MSG_LONG  = 64,
    parameter int MSG_SHORT = 16,
    localparam int CW       = $clog2(NUM_CH + 1),
    localparam int AW       = $clog2(MSG_LONG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH*MODE_W-1:0] mode_sel,
    input  logic                     rx_vld,
    input  logic [CW-1:0]            rx_chan,
    input  logic [BYTE_W-1:0]        rx_byte,
    input  logic                     exp_we,
    input  logic [CW-1:0]            exp_chan,
    input  logic [AW-1:0]            exp_addr,
    input  logic [BYTE_W-1:0]        exp_data,
    input  logic [NUM_CH-1:0]        irq_mask,
    input  logic [NUM_CH-1:0]        delta_clr,
    output logic [NUM_CH-1:0]        tim_state,
    output logic [NUM_CH-1:0]        tim_delta,
    output logic                     irq
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [AW-1:0]     rd_addr;
        logic [BYTE_W-1:0] rd_data;
        logic              wr_sel, rx_sel;

        assign wr_sel = exp_we && (exp_chan == CW'(g));
        assign rx_sel = rx_vld && (rx_chan == CW'(g));

        trace_exp_store #(.DEPTH(MSG_LONG), .DATA_W(BYTE_W)) u_store (
            .clk   (clk),
            .we    (wr_sel),
            .waddr (exp_addr),
            .wdata (exp_data),
            .raddr (rd_addr),
            .rdata (rd_data)
        );

        trace_chan_fsm #(.MSG_LONG(MSG_LONG), .MSG_SHORT(MSG_SHORT)) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode      (mode_sel[g*MODE_W +: MODE_W]),
            .byte_vld  (rx_sel),
            .byte_in   (rx_byte),
            .rd_addr   (rd_addr),
            .rd_data   (rd_data),
            .delta_clr (delta_clr[g]),
            .tim_o     (tim_state[g]),
            .delta_o   (tim_delta[g])
        );
    end

    assign irq = |(tim_delta & irq_mask);

    // R8
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == '0) |-> !irq);
    // R8
    unflagged_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tim_delta == '0) |-> !irq);
endmodule

// File: tb/test_trace_id_monitor.sv
module test_trace_id_monitor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] mode_sel = '0;
    logic       rx_vld = 1'b0;
    logic [1:0] rx_chan = '0;
    logic [7:0] rx_byte = '0;
    logic       exp_we = 1'b0;
    logic [1:0] exp_chan = '0;
    logic [5:0] exp_addr = '0;
    logic [7:0] exp_data = '0;
    logic [2:0] irq_mask = '0;
    logic [2:0] delta_clr = '0;
    logic [2:0] tim_state, tim_delta;
    logic       irq;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    trace_id_monitor i_trace_id_monitor (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .rx_vld(rx_vld),
        .rx_chan(rx_chan), .rx_byte(rx_byte), .exp_we(exp_we),
        .exp_chan(exp_chan), .exp_addr(exp_addr), .exp_data(exp_data),
        .irq_mask(irq_mask), .delta_clr(delta_clr), .tim_state(tim_state),
        .tim_delta(tim_delta), .irq(irq)
    );

    function automatic logic [7:0] long_msg(int i);
        return (i == 63) ? 8'h0A : 8'(8'h20 + i);
    endfunction
    function automatic logic [7:0] short_msg(int i);
        return (i == 0) ? 8'h85 : 8'(8'h30 + i);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(int ch, logic [7:0] b);
        rx_vld = 1'b1; rx_chan = 2'(ch); rx_byte = b;
        @(negedge clk);
        rx_vld = 1'b0;
    endtask

    task automatic wr_exp(int ch, int a, logic [7:0] d);
        exp_we = 1'b1; exp_chan = 2'(ch); exp_addr = 6'(a); exp_data = d;
        @(negedge clk);
        exp_we = 1'b0;
    endtask

    task automatic set_mode(int ch, logic [2:0] m);
        mode_sel[ch*3 +: 3] = m;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic clear_delta(logic [2:0] m);
        delta_clr = m;
        @(negedge clk);
        delta_clr = '0;
    endtask

    // long message; bad_at < 0 means none corrupted; stop_early sends one byte fewer
    task automatic send_long(int ch, int bad_at, bit stop_early);
        for (int i = 0; i < (stop_early ? 63 : 64); i++)
            send(ch, (i == bad_at) ? 8'h7F : long_msg(i));
    endtask

    task automatic send_short(int ch, int bad_at);
        for (int i = 0; i < 16; i++)
            send(ch, (i == bad_at) ? 8'h11 : short_msg(i));
    endtask

    task automatic t_reset;
        check("R7 reset delta", 32'(tim_delta), 0);
        check("R5 reset state", 32'(tim_state), 0);
        check("R8 reset irq", 32'(irq), 0);
    endtask

    task automatic t_long;
        set_mode(0, 3'b100);
        set_mode(1, 3'b100);
        for (int i = 0; i < 10; i++) send(0, 8'h41);
        check("R4 hunting holds state", 32'(tim_state[0]), 0);
        send(0, 8'h0A);
        send_long(0, -1, 0);
        check("R2 aligned good window", 32'(tim_state[0]), 0);
        check("R6 no delta on good", 32'(tim_delta[0]), 0);
        send_long(0, 5, 1);
        check("R5 not yet evaluated", 32'(tim_state[0]), 0);
        send(0, long_msg(63));
        check("R5 mismatch at window end", 32'(tim_state[0]), 1);
        check("R7 delta on set", 32'(tim_delta[0]), 1);
        check("R8 masked irq", 32'(irq), 0);
        irq_mask = 3'b001;
        #1;
        check("R8 enabled irq", 32'(irq), 1);
        clear_delta(3'b001);
        check("R7 delta cleared", 32'(tim_delta[0]), 0);
        check("R8 irq drops", 32'(irq), 0);
        check("R7 state kept after clear", 32'(tim_state[0]), 1);
        // window ending without terminator: verdict then lose alignment
        send_long(0, 63, 0);
        for (int i = 0; i < 20; i++) send(0, long_msg(i));
        check("R4 hold after losing lock", 32'(tim_state[0]), 1);
        check("R2 unchanged while hunting", 32'(tim_delta[0]), 0);
        send(0, 8'h0A);
        send_long(0, -1, 0);
        check("R6 cleared by good window", 32'(tim_state[0]), 0);
        check("R7 delta on clear", 32'(tim_delta[0]), 1);
        check("R9 other channel untouched", 32'(tim_state[2:1]), 0);
        check("R9 other delta untouched", 32'(tim_delta[2:1]), 0);
        clear_delta(3'b001);
    endtask

    task automatic t_short;
        set_mode(2, 3'b101);
        send(2, 8'h31);
        send(2, 8'h32);
        send_short(2, 3);
        check("R3 short mismatch", 32'(tim_state[2]), 1);
        check("R9 ch0 stays", 32'(tim_state[0]), 0);
        irq_mask = 3'b100;
        #1;
        check("R8 ch2 irq", 32'(irq), 1);
        send(2, 8'h05);
        send_short(2, -1);
        check("R3 short good window", 32'(tim_state[2]), 0);
        clear_delta(3'b100);
        send_short(2, 15);
        check("R3 last byte mismatch", 32'(tim_state[2]), 1);
    endtask

    task automatic t_undef;
        clear_delta(3'b100);
        mode_sel[8:6] = 3'b110;
        @(negedge clk);
        check("R1 undefined forces clear", 32'(tim_state[2]), 0);
        check("R1 delta on forced clear", 32'(tim_delta[2]), 1);
        send(2, 8'h85);
        for (int i = 0; i < 16; i++) send(2, 8'h00);
        check("R1 disabled ignores bytes", 32'(tim_state[2]), 0);
        mode_sel[2:0] = 3'b111;
        @(negedge clk);
        send(0, 8'h0A);
        send_long(0, 2, 0);
        check("R1 code 111 disabled", 32'(tim_state[0]), 0);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        for (int i = 0; i < 64; i++) wr_exp(0, i, long_msg(i));
        for (int i = 0; i < 64; i++) wr_exp(1, i, 8'h00);
        for (int i = 0; i < 16; i++) wr_exp(2, i, short_msg(i));
        t_long();
        t_short();
        t_undef();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule